// File: doc/BRIEF.md
# MFM Sector Field Writer

This block turns one soft-sectored field update into a modified-frequency-modulation flux stream for a disk write channel. On a start command it emits a run of zero sync bytes, a two-byte address mark whose first byte carries a deliberately missing clock, the payload (either a three-byte cylinder/head/sector identifier or a block of user data), a 16-bit check word and a short zero postamble. Every byte becomes sixteen encoded cells, and each cell lasts a programmable number of system clocks.

The write-gate output covers the whole field. The write-data output carries one single-clock pulse at the centre of every cell whose encoded value is 1. Payload bytes for a data field are pulled from a show-ahead byte source. The block raises a read strobe in the cycle in which it takes `data_i`, and the source presents the next byte afterwards.

Top module: `mfmw_field_writer`

## Requirements
- R1: After reset, and until a start is accepted, `wr_gate_o`, `wr_data_o` and `data_rd_o` are all 0.
- R2: With `field_data_i`=0 the byte order is: `SYNC_ID_BYTES` (13) bytes of 00, A1, FE, cylinder, head, sector, check high byte, check low byte, then `TAIL_BYTES` (3) bytes of 00. The cylinder, head and sector values are the ones captured in the start cycle.
- R3: With `field_data_i`=1 the byte order is: `SYNC_DATA_BYTES` (12) bytes of 00, A1, F8, `DATA_BYTES` payload bytes taken from `data_i`, check high byte, check low byte, then 3 bytes of 00.
- R4: Each byte is sent MSB first as eight cell pairs, with the clock cell before the data cell. The data cell equals the bit. The clock cell is 1 only when both this bit and the bit sent before it are 0, and this holds across byte boundaries. The bit before the first sync byte counts as 0.
- R5: The A1 byte of the address mark has the clock cell in front of data bit 2 forced to 0, so its sixteen cells read 0x4489 (first cell in the MSB).
- R6: The check word is CRC-16 with polynomial 0x1021, preset FFFF, shifted MSB first. It covers the A1 byte, the tag byte and the payload, and it is sent high byte first.
- R7: Each cell lasts `CLKS_PER_CELL` clocks. A cell of value 1 gives exactly one one-clock pulse on `wr_data_o`, at clock offset `CLKS_PER_CELL/2` within the cell (offset 0 is the first clock of the cell). A cell of value 0 gives no pulse.
- R8: `wr_gate_o` rises in the clock after an accepted start. It stays high for exactly (bytes x 16 x `CLKS_PER_CELL`) clocks and then falls. `wr_data_o` pulses only while the gate is high.
- R9: A start while `wr_gate_o` is high is ignored. The field in progress keeps its type, its captured address bytes and its length.
- R10: `data_rd_o` pulses once per payload byte of a data field (`DATA_BYTES` times in total) and never during an ID field. `data_i` is taken in the same cycle as the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start a field update (taken only when idle) |
| field_data_i | input | 1 | Field type: 0 = ID field, 1 = data field |
| cyl_i | input | 8 | Cylinder byte for an ID field |
| head_i | input | 8 | Head byte for an ID field |
| sect_i | input | 8 | Sector byte for an ID field |
| data_i | input | 8 | Show-ahead payload byte for a data field |
| data_rd_o | output | 1 | Payload byte taken this cycle |
| wr_data_o | output | 1 | Flux-transition pulse, one clock per 1-cell |
| wr_gate_o | output | 1 | Write enable covering the whole field |

## Verification
The bench builds the block with `CLKS_PER_CELL`=4 and `DATA_BYTES`=8, while keeping the full sync and postamble lengths. With these values every cell of every field can be captured and compared against a stream the bench computes itself. It runs a sweep of ID fields whose address bytes span 00 to FF, and data fields with incrementing, all-ones, all-zeros and alternating payloads. These payloads exercise both clock-cell cases at byte boundaries and a range of check words. Two of the runs inject a competing start with a different type and address in the middle of the field, to show that it has no effect.

// File: rtl/mfmw_pkg.sv
package mfmw_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SYNC,
        PH_MARK,
        PH_TAG,
        PH_BODY,
        PH_CHK_HI,
        PH_CHK_LO,
        PH_TAIL
    } mfmw_phase_e;

    localparam logic [7:0]  MARK_BYTE       = 8'hA1;
    localparam logic [7:0]  ID_TAG_BYTE     = 8'hFE;
    localparam logic [7:0]  DATA_TAG_BYTE   = 8'hF8;
    localparam logic [15:0] CRC_POLY        = 16'h1021;
    localparam logic [15:0] CRC_SEED        = 16'hFFFF;
    // clock cell ahead of data bit 2 is the one the mark suppresses
    localparam logic [15:0] MARK_CLOCK_HOLE = 16'h0020;

    function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] b);
        logic [15:0] r;
        r = c;
        for (int i = 7; i >= 0; i--) begin
            if (r[15] ^ b[i]) r = {r[14:0], 1'b0} ^ CRC_POLY;
            else              r = {r[14:0], 1'b0};
        end
        return r;
    endfunction

    // cell pairs: [2i+1] clock, [2i] data for byte bit i
    function automatic logic [15:0] mfm_cells(input logic [7:0] b, input logic prev,
                                              input logic mark);
        logic [15:0] p;
        logic        last;
        p    = '0;
        last = prev;
        for (int i = 7; i >= 0; i--) begin
            p[2*i+1] = ~last & ~b[i];
            p[2*i]   = b[i];
            last     = b[i];
        end
        if (mark) p = p & ~MARK_CLOCK_HOLE;
        return p;
    endfunction

endpackage

// File: rtl/mfmw_cell_timer.sv
module mfmw_cell_timer #(
    parameter int CELL_CLKS = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic cell_end_o,
    output logic mid_o
);
    localparam int TW = (CELL_CLKS > 2) ? $clog2(CELL_CLKS) : 1;
    localparam logic [TW-1:0] LAST = TW'(CELL_CLKS - 1);
    localparam logic [TW-1:0] MID  = TW'(CELL_CLKS / 2);

    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = '0;
        if (run_i) cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cell_end_o = run_i && (cnt_q == LAST);
    assign mid_o      = run_i && (cnt_q == MID);
endmodule

// File: rtl/mfmw_shifter.sv
module mfmw_shifter (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load_i,
    input  logic [15:0] pat_i,
    input  logic        step_i,
    output logic        cell_o,
    output logic        byte_done_o
);
    typedef struct packed {
        logic [15:0] pat;
        logic [3:0]  idx;
    } sh_t;

    sh_t sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (load_i) begin
            sh_d.pat = pat_i;
            sh_d.idx = '0;
        end else if (step_i) begin
            sh_d.pat = {sh_q.pat[14:0], 1'b0};
            sh_d.idx = sh_q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign cell_o      = sh_q.pat[15];
    assign byte_done_o = step_i && (sh_q.idx == 4'd15);
endmodule

// File: rtl/mfmw_crc16.sv
module mfmw_crc16
    import mfmw_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        init_i,
    input  logic        upd_i,
    input  logic [7:0]  byte_i,
    output logic [15:0] crc_o
);
    logic [15:0] crc_d, crc_q;

    always_comb begin
        crc_d = crc_q;
        if (init_i)     crc_d = CRC_SEED;
        else if (upd_i) crc_d = crc_step(crc_q, byte_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) crc_q <= CRC_SEED;
        else        crc_q <= crc_d;
    end

    assign crc_o = crc_q;
endmodule

// File: rtl/mfmw_field_writer.sv
module mfmw_field_writer
    import mfmw_pkg::*;
#(
    parameter int CLKS_PER_CELL   = 10,
    parameter int DATA_BYTES      = 256,
    parameter int SYNC_ID_BYTES   = 13,
    parameter int SYNC_DATA_BYTES = 12,
    parameter int TAIL_BYTES      = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       field_data_i,
    input  logic [7:0] cyl_i,
    input  logic [7:0] head_i,
    input  logic [7:0] sect_i,
    input  logic [7:0] data_i,
    output logic       data_rd_o,
    output logic       wr_data_o,
    output logic       wr_gate_o
);
    localparam int M1   = (SYNC_ID_BYTES > SYNC_DATA_BYTES) ? SYNC_ID_BYTES : SYNC_DATA_BYTES;
    localparam int M2   = (DATA_BYTES > TAIL_BYTES) ? DATA_BYTES : TAIL_BYTES;
    localparam int M3   = (M1 > M2) ? M1 : M2;
    localparam int MAXN = (M3 > 3) ? M3 : 3;
    localparam int CW   = $clog2(MAXN);

    localparam logic [CW-1:0] SYNC_ID_LAST   = CW'(SYNC_ID_BYTES - 1);
    localparam logic [CW-1:0] SYNC_DATA_LAST = CW'(SYNC_DATA_BYTES - 1);
    localparam logic [CW-1:0] BODY_ID_LAST   = CW'(2);
    localparam logic [CW-1:0] BODY_DATA_LAST = CW'(DATA_BYTES - 1);
    localparam logic [CW-1:0] TAIL_LAST      = CW'(TAIL_BYTES - 1);

    typedef struct packed {
        logic        busy;
        mfmw_phase_e phase;
        logic [CW-1:0] cnt;
        logic        is_data;
        logic [7:0]  cyl;
        logic [7:0]  head;
        logic [7:0]  sect;
        logic        last_bit;
    } st_t;

    st_t st_d, st_q;

    logic        cell_end, at_mid, cell_bit, byte_done;
    logic        load, mark, crc_init, crc_upd, rd;
    logic [7:0]  nxt_byte;
    logic [15:0] nxt_pat, crc;

    mfmw_cell_timer #(.CELL_CLKS(CLKS_PER_CELL)) timer_i (
        .clk(clk), .rst_n(rst_n), .run_i(st_q.busy),
        .cell_end_o(cell_end), .mid_o(at_mid)
    );

    mfmw_shifter shifter_i (
        .clk(clk), .rst_n(rst_n), .load_i(load), .pat_i(nxt_pat),
        .step_i(cell_end), .cell_o(cell_bit), .byte_done_o(byte_done)
    );

    mfmw_crc16 crc_i (
        .clk(clk), .rst_n(rst_n), .init_i(crc_init), .upd_i(crc_upd),
        .byte_i(nxt_byte), .crc_o(crc)
    );

    always_comb begin
        mfmw_phase_e   adv_phase;
        logic [CW-1:0] adv_cnt;
        logic          finish;
        logic          prev;

        st_d      = st_q;
        load      = 1'b0;
        mark      = 1'b0;
        crc_init  = 1'b0;
        crc_upd   = 1'b0;
        rd        = 1'b0;
        nxt_byte  = 8'h00;
        adv_phase = st_q.phase;
        adv_cnt   = st_q.cnt + 1'b1;
        finish    = 1'b0;
        prev      = st_q.last_bit;

        if (!st_q.busy) begin
            if (start_i) begin
                st_d.busy    = 1'b1;
                st_d.phase   = PH_SYNC;
                st_d.cnt     = '0;
                st_d.is_data = field_data_i;
                st_d.cyl     = cyl_i;
                st_d.head    = head_i;
                st_d.sect    = sect_i;
                load         = 1'b1;
                crc_init     = 1'b1;
                prev         = 1'b0;
            end
        end else if (byte_done) begin
            case (st_q.phase)
                PH_SYNC: if (st_q.cnt == (st_q.is_data ? SYNC_DATA_LAST : SYNC_ID_LAST)) begin
                    adv_phase = PH_MARK;
                    adv_cnt   = '0;
                end
                PH_MARK:   begin adv_phase = PH_TAG;    adv_cnt = '0; end
                PH_TAG:    begin adv_phase = PH_BODY;   adv_cnt = '0; end
                PH_BODY: if (st_q.cnt == (st_q.is_data ? BODY_DATA_LAST : BODY_ID_LAST)) begin
                    adv_phase = PH_CHK_HI;
                    adv_cnt   = '0;
                end
                PH_CHK_HI: begin adv_phase = PH_CHK_LO; adv_cnt = '0; end
                PH_CHK_LO: begin adv_phase = PH_TAIL;   adv_cnt = '0; end
                PH_TAIL:   finish = (st_q.cnt == TAIL_LAST);
                default:   finish = 1'b1;
            endcase

            if (finish) begin
                st_d.busy  = 1'b0;
                st_d.phase = PH_IDLE;
                st_d.cnt   = '0;
            end else begin
                st_d.phase = adv_phase;
                st_d.cnt   = adv_cnt;
                load       = 1'b1;
                case (adv_phase)
                    PH_MARK: begin
                        nxt_byte = MARK_BYTE;
                        mark     = 1'b1;
                        crc_upd  = 1'b1;
                    end
                    PH_TAG: begin
                        nxt_byte = st_q.is_data ? DATA_TAG_BYTE : ID_TAG_BYTE;
                        crc_upd  = 1'b1;
                    end
                    PH_BODY: begin
                        crc_upd = 1'b1;
                        if (st_q.is_data) begin
                            nxt_byte = data_i;
                            rd       = 1'b1;
                        end else if (adv_cnt == '0) begin
                            nxt_byte = st_q.cyl;
                        end else if (adv_cnt == CW'(1)) begin
                            nxt_byte = st_q.head;
                        end else begin
                            nxt_byte = st_q.sect;
                        end
                    end
                    PH_CHK_HI: nxt_byte = crc[15:8];
                    PH_CHK_LO: nxt_byte = crc[7:0];
                    default:   nxt_byte = 8'h00;
                endcase
            end
        end

        if (load) st_d.last_bit = nxt_byte[0];
        nxt_pat = mfm_cells(nxt_byte, prev, mark);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{busy: 1'b0, phase: PH_IDLE, cnt: '0, is_data: 1'b0,
                              cyl: 8'h00, head: 8'h00, sect: 8'h00, last_bit: 1'b0};
        else        st_q <= st_d;
    end

    assign wr_gate_o = st_q.busy;
    assign wr_data_o = st_q.busy && at_mid && cell_bit;
    assign data_rd_o = rd;
endmodule

// File: rtl/mfmw_field_writer_chk.sv
module mfmw_field_writer_chk #(
    parameter int DATA_BYTES = 256
) (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic data_rd_o,
    input logic wr_data_o,
    input logic wr_gate_o
);
    int unsigned rd_cnt_d, rd_cnt_q;

    always_comb begin
        rd_cnt_d = rd_cnt_q;
        if (!wr_gate_o)     rd_cnt_d = 0;
        else if (data_rd_o) rd_cnt_d = rd_cnt_q + 1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_cnt_q <= 0;
        else        rd_cnt_q <= rd_cnt_d;
    end

    a_r8_pulse_in_gate: assert property (@(posedge clk) disable iff (!rst_n)
        wr_data_o |-> wr_gate_o);

    a_r7_single_clock_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        wr_data_o |=> !wr_data_o);

    a_r10_read_in_gate: assert property (@(posedge clk) disable iff (!rst_n)
        data_rd_o |-> wr_gate_o);

    a_r10_read_budget: assert property (@(posedge clk) disable iff (!rst_n)
        data_rd_o |-> (rd_cnt_q < DATA_BYTES));

    a_r8_gate_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_gate_o) |-> $past(start_i));
endmodule

bind mfmw_field_writer mfmw_field_writer_chk #(.DATA_BYTES(DATA_BYTES)) chk_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .data_rd_o(data_rd_o),
    .wr_data_o(wr_data_o), .wr_gate_o(wr_gate_o)
);

// File: tb/mfmw_field_writer_tb_top.sv
module mfmw_field_writer_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int CPC  = 4;
    localparam int DB   = 8;
    localparam int SID  = 13;
    localparam int SDA  = 12;
    localparam int TAIL = 3;
    localparam int MID  = CPC / 2;
    localparam int MAXB = SID + 2 + DB + 2 + TAIL;
    localparam int MAXC = MAXB * 16;

    logic clk = 1'b0, rst_n = 1'b0;
    logic start_i = 1'b0, field_data_i = 1'b0;
    logic [7:0] cyl_i = '0, head_i = '0, sect_i = '0, data_i = '0;
    logic data_rd_o, wr_data_o, wr_gate_o;

    mfmw_field_writer #(.CLKS_PER_CELL(CPC), .DATA_BYTES(DB), .SYNC_ID_BYTES(SID),
                        .SYNC_DATA_BYTES(SDA), .TAIL_BYTES(TAIL)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .field_data_i(field_data_i),
        .cyl_i(cyl_i), .head_i(head_i), .sect_i(sect_i), .data_i(data_i),
        .data_rd_o(data_rd_o), .wr_data_o(wr_data_o), .wr_gate_o(wr_gate_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0, fails = 0;
    bit done = 0;
    int dmode = 0, didx = 0;
    logic [7:0] eb [MAXB];
    logic       ec [MAXC];
    logic       cap[MAXC];

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pay(input int m, input int i);
        case (m)
            0: return 8'(i * 37 + 5);
            1: return 8'hFF;
            2: return 8'h00;
            default: return (i % 2 == 1) ? 8'hAA : 8'h55;
        endcase
    endfunction

    function automatic logic [15:0] crc_b(input logic [15:0] c, input logic [7:0] b);
        logic [15:0] r = c;
        for (int k = 0; k < 8; k++) begin
            logic fb = r[15] ^ b[7-k];
            r = {r[14:0], 1'b0};
            if (fb) r = r ^ 16'h1021;
        end
        return r;
    endfunction

    function automatic logic [15:0] enc(input logic [7:0] b, input logic prev, input bit mk);
        logic [15:0] w = '0;
        logic p = prev;
        for (int k = 0; k < 8; k++) begin
            logic d = b[7-k];
            w = {w[13:0], (p == 1'b0 && d == 1'b0), d};
            p = d;
        end
        if (mk) w[5] = 1'b0;
        return w;
    endfunction

    // show-ahead payload source
    initial forever begin
        @(negedge clk);
        if (data_rd_o === 1'b1) begin
            @(posedge clk);
            #1;
            didx++;
            data_i = pay(dmode, didx);
        end
    end

    task automatic run_field(input bit isd, input logic [7:0] c, input logic [7:0] h,
                             input logic [7:0] s, input int mode, input bit extra);
        int n = 0, markpos, chkpos, t = 0, rd_cnt = 0, badpos = 0, mis = 0, bmis = 0;
        int first_mis = -1;
        logic [15:0] crc = 16'hFFFF, mk_cells = '0, got_crc = '0;
        logic prev = 1'b0;
        string rq;
        rq = isd ? "R3" : "R2";
        for (int i = 0; i < (isd ? SDA : SID); i++) eb[n++] = 8'h00;
        markpos = n;
        eb[n++] = 8'hA1;
        eb[n++] = isd ? 8'hF8 : 8'hFE;
        if (isd) for (int i = 0; i < DB; i++) eb[n++] = pay(mode, i);
        else begin eb[n++] = c; eb[n++] = h; eb[n++] = s; end
        for (int i = markpos; i < n; i++) crc = crc_b(crc, eb[i]);
        chkpos = n;
        eb[n++] = crc[15:8];
        eb[n++] = crc[7:0];
        for (int i = 0; i < TAIL; i++) eb[n++] = 8'h00;
        for (int j = 0; j < n; j++) begin
            logic [15:0] w = enc(eb[j], prev, j == markpos);
            for (int k = 0; k < 16; k++) ec[j*16+k] = w[15-k];
            prev = eb[j][0];
        end
        for (int i = 0; i < MAXC; i++) cap[i] = 1'b0;

        dmode = mode; didx = 0; data_i = pay(mode, 0);
        @(negedge clk);
        field_data_i = isd; cyl_i = c; head_i = h; sect_i = s; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(wr_gate_o === 1'b1, "R8 gate opens one clock after start", 64'(wr_gate_o), 1);
        while (wr_gate_o === 1'b1 && t < MAXC * CPC + 16) begin
            if (wr_data_o === 1'b1) begin
                if (t % CPC != MID) badpos++;
                else if (t / CPC < MAXC) cap[t/CPC] = 1'b1;
            end
            if (data_rd_o === 1'b1) rd_cnt++;
            if (extra && t == 40) begin
                start_i = 1'b1; field_data_i = !isd; cyl_i = ~c; head_i = ~h; sect_i = ~s;
            end else if (extra && t == 41) start_i = 1'b0;
            t++;
            @(negedge clk);
        end
        for (int i = 0; i < n * 16; i++) if (cap[i] !== ec[i]) begin
            mis++;
            if (first_mis < 0) first_mis = i;
        end
        for (int j = 0; j < n; j++) begin
            logic [7:0] b = '0;
            for (int k = 0; k < 8; k++) b[7-k] = cap[j*16 + 2*k + 1];
            if (b !== eb[j]) bmis++;
            if (j == chkpos)     got_crc[15:8] = b;
            if (j == chkpos + 1) got_crc[7:0]  = b;
        end
        for (int k = 0; k < 16; k++) mk_cells[15-k] = cap[markpos*16 + k];

        chk(mis == 0, "R4 encoded cell stream", first_mis, -1);
        chk(bmis == 0, {rq, " byte sequence of field"}, bmis, 0);
        chk(mk_cells == 16'h4489, "R5 address-mark cells", mk_cells, 16'h4489);
        chk(got_crc == crc, "R6 check word", got_crc, crc);
        chk(badpos == 0, "R7 pulse at cell centre", badpos, 0);
        chk(t == n * 16 * CPC, extra ? "R9 length kept despite second start" :
                                       "R8 gate length", t, n * 16 * CPC);
        chk(rd_cnt == (isd ? DB : 0), "R10 payload read strobes", rd_cnt, isd ? DB : 0);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(wr_gate_o === 1'b0 && wr_data_o === 1'b0 && data_rd_o === 1'b0,
            "R1 idle outputs after reset", {wr_gate_o, wr_data_o, data_rd_o}, 0);
        for (int i = 0; i < 6; i++)
            run_field(1'b0, 8'(i * 51), 8'(i), 8'(1 + i * 3), 0, 1'b0);
        for (int m = 0; m < 4; m++)
            run_field(1'b1, 8'h00, 8'h00, 8'h00, m, 1'b0);
        run_field(1'b1, 8'h00, 8'h00, 8'h00, 0, 1'b1);   // R9 data field
        run_field(1'b0, 8'h3C, 8'h05, 8'h11, 0, 1'b1);   // R9 ID field
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog run did not complete actual=0x0 expected=0x1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule